// File: doc/BRIEF.md
# Hardware Thread Context Run-State Controller

This block holds the run state of a set of hardware thread contexts inside a multithreaded or multiprocessor core. Each context takes four commands: start it after a programmable number of cycles, park it temporarily, release it back to the unassigned pool, or shut it down for good. The block tells the issue logic which contexts may issue instructions. It raises a single terminate flag once every context has shut down.

Each context has its own command pins and its own delay lane. A start request loads a per-context down-counter. The context becomes runnable only when that count expires. Parking or releasing a context while its count is still running cancels the pending start. A context that has been shut down ignores every command until reset. Fetch, scheduling policy and register state are handled elsewhere.

Top module: `ctx_status_ctrl`

## Requirements
- R1: `state_o` carries two bits per context, context i at bits [2i+1:2i], encoded 0 = unassigned, 1 = running, 2 = parked, 3 = shut down.
- R2: While reset is low and after it is released, every context reads unassigned, `exec_en_o` is all zero and `all_halted_o` is low.
- R3: A start request with lane value D, made to a context that is not running, makes it running after exactly max(D,1) rising clock edges, and its state is unchanged before then. A new start request during the countdown restarts the count with the new value. A start request to a running context has no effect.
- R4: `exec_en_o[i]` is high exactly when context i is running.
- R5: A park command moves any context that is not shut down to parked on the next edge. A later start request resumes the context.
- R6: A release command moves any context that is not shut down to unassigned on the next edge.
- R7: A park or release command that arrives during a start countdown cancels the countdown, so the context does not later become running.
- R8: A shut-down command moves a context to shut down on the next edge. A shut-down context ignores all commands and leaves that state only through reset.
- R9: `all_halted_o` is high exactly when every context is shut down.
- R10: When several commands reach one context in the same cycle, shut-down wins over release, release over park, and park over start.
- R11: Commands to one context never change the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | NCTX | Start request per context |
| cmd_park_i | input | NCTX | Park request per context |
| cmd_free_i | input | NCTX | Release request per context |
| cmd_kill_i | input | NCTX | Shut-down request per context |
| start_dly_i | input | NCTX*DW | Start delay lane per context, lane i at bits [DW*i+DW-1:DW*i] |
| state_o | output | 2*NCTX | Current state per context (R1 encoding) |
| exec_en_o | output | NCTX | Issue permission per context |
| all_halted_o | output | 1 | All contexts are shut down |

## Verification
Two things can land on one context in the same cycle: a start countdown still in flight and a new command, or several command pins asserted together. The bench starts long countdowns and then parks, releases or restarts the context partway through. It judges the result by watching the context for the rest of the window and confirming that no late transition to running appears. It also drives every non-empty combination of the four command pins at once, from both a running and a parked context, and compares the next state against the stated priority order.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [1:0] {
        CTX_IDLE = 2'd0,
        CTX_RUN  = 2'd1,
        CTX_WAIT = 2'd2,
        CTX_DEAD = 2'd3
    } ctx_state_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_PARK  = 3'd2,
        OP_FREE  = 3'd3,
        OP_KILL  = 3'd4
    } ctx_op_e;

endpackage

// File: rtl/ctx_cmd_prio.sv
module ctx_cmd_prio
    import ctx_pkg::*;
(
    input  logic    start_i,
    input  logic    park_i,
    input  logic    free_i,
    input  logic    kill_i,
    output ctx_op_e op_o
);

    // Fixed precedence: kill, free, park, start
    always_comb begin
        if (kill_i)       op_o = OP_KILL;
        else if (free_i)  op_o = OP_FREE;
        else if (park_i)  op_o = OP_PARK;
        else if (start_i) op_o = OP_START;
        else              op_o = OP_NONE;
    end

endmodule

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctx_op_e       op_i,
    input  logic [DW-1:0] delay_i,
    output ctx_state_e    state_o,
    output logic          exec_o
);

    localparam logic [DW-1:0] ONE = DW'(1);

    typedef struct packed {
        ctx_state_e    state;
        logic [DW-1:0] cnt;    // cycles left before going to run, 0 = none pending
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.state != CTX_DEAD) begin
            case (op_i)
                OP_KILL: begin
                    slot_d.state = CTX_DEAD;
                    slot_d.cnt   = '0;
                end
                OP_FREE: begin
                    slot_d.state = CTX_IDLE;
                    slot_d.cnt   = '0;
                end
                OP_PARK: begin
                    slot_d.state = CTX_WAIT;
                    slot_d.cnt   = '0;
                end
                OP_START: begin
                    if (slot_q.state != CTX_RUN) begin
                        if (delay_i <= ONE) begin
                            slot_d.state = CTX_RUN;
                            slot_d.cnt   = '0;
                        end else begin
                            slot_d.cnt   = delay_i - ONE;
                        end
                    end
                end
                default: begin
                    if (slot_q.cnt != '0) begin
                        if (slot_q.cnt == ONE) begin
                            slot_d.state = CTX_RUN;
                        end
                        slot_d.cnt = slot_q.cnt - ONE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.state <= CTX_IDLE;
            slot_q.cnt   <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign state_o = slot_q.state;
    assign exec_o  = (slot_q.state == CTX_RUN);

endmodule

// File: rtl/ctx_status_ctrl.sv
module ctx_status_ctrl
    import ctx_pkg::*;
#(
    parameter int NCTX = 4,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCTX-1:0]    cmd_start_i,
    input  logic [NCTX-1:0]    cmd_park_i,
    input  logic [NCTX-1:0]    cmd_free_i,
    input  logic [NCTX-1:0]    cmd_kill_i,
    input  logic [NCTX*DW-1:0] start_dly_i,
    output logic [2*NCTX-1:0]  state_o,
    output logic [NCTX-1:0]    exec_en_o,
    output logic               all_halted_o
);

    localparam int SW = 2;

    ctx_state_e st_w [NCTX];

    for (genvar i = 0; i < NCTX; i++) begin : g_ctx
        ctx_op_e op_w;

        ctx_cmd_prio u_prio (
            .start_i (cmd_start_i[i]),
            .park_i  (cmd_park_i[i]),
            .free_i  (cmd_free_i[i]),
            .kill_i  (cmd_kill_i[i]),
            .op_o    (op_w)
        );

        ctx_slot #(.DW(DW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_i    (op_w),
            .delay_i (start_dly_i[DW*i +: DW]),
            .state_o (st_w[i]),
            .exec_o  (exec_en_o[i])
        );

        assign state_o[SW*i +: SW] = st_w[i];
    end

    always_comb begin
        all_halted_o = 1'b1;
        for (int k = 0; k < NCTX; k++) begin
            if (st_w[k] != CTX_DEAD) all_halted_o = 1'b0;
        end
    end

endmodule

// File: rtl/ctx_status_chk.sv
module ctx_status_chk #(
    parameter int NCTX = 4,
    parameter int DW   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NCTX-1:0]    cmd_start_i,
    input logic [NCTX-1:0]    cmd_park_i,
    input logic [NCTX-1:0]    cmd_free_i,
    input logic [NCTX-1:0]    cmd_kill_i,
    input logic [NCTX*DW-1:0] start_dly_i,
    input logic [2*NCTX-1:0]  state_o,
    input logic [NCTX-1:0]    exec_en_o,
    input logic               all_halted_o
);

    for (genvar i = 0; i < NCTX; i++) begin : g_chk
        // R8: a shut-down context stays shut down
        a_r8_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            state_o[2*i +: 2] == 2'd3 |=> state_o[2*i +: 2] == 2'd3);

        // R10: shut-down wins over everything
        a_r10_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_kill_i[i] |=> state_o[2*i +: 2] == 2'd3);

        // R6: release on a live context
        a_r6_free: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_free_i[i] && !cmd_kill_i[i] && state_o[2*i +: 2] != 2'd3)
            |=> state_o[2*i +: 2] == 2'd0);

        // R5: park on a live context
        a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_park_i[i] && !cmd_free_i[i] && !cmd_kill_i[i] && state_o[2*i +: 2] != 2'd3)
            |=> state_o[2*i +: 2] == 2'd2);

        // R3: unit delay start
        a_r3_start_fast: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_start_i[i] && !cmd_park_i[i] && !cmd_free_i[i] && !cmd_kill_i[i]
             && start_dly_i[DW*i +: DW] <= DW'(1) && state_o[2*i +: 2] != 2'd3)
            |=> state_o[2*i +: 2] == 2'd1);

        // R4 with R9: no context may issue once all are shut down
        a_r4_no_exec_when_done: assert property (@(posedge clk) disable iff (!rst_n)
            exec_en_o[i] |-> !all_halted_o);

        // R9: terminate implies this context is shut down
        a_r9_all_dead: assert property (@(posedge clk) disable iff (!rst_n)
            all_halted_o |-> state_o[2*i +: 2] == 2'd3);
    end

    // R9: termination is permanent until reset
    a_r9_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        all_halted_o |=> all_halted_o);

endmodule

bind ctx_status_ctrl ctx_status_chk #(.NCTX(NCTX), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start_i  (cmd_start_i),
    .cmd_park_i   (cmd_park_i),
    .cmd_free_i   (cmd_free_i),
    .cmd_kill_i   (cmd_kill_i),
    .start_dly_i  (start_dly_i),
    .state_o      (state_o),
    .exec_en_o    (exec_en_o),
    .all_halted_o (all_halted_o)
);

// File: tb/ctx_status_ctrl_tb.sv
module ctx_status_ctrl_tb;

    localparam int N  = 3;
    localparam int DW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [N-1:0]    c_start, c_park, c_free, c_kill;
    logic [N*DW-1:0] dly;
    logic [2*N-1:0]  state_o;
    logic [N-1:0]    exec_en_o;
    logic            all_halted_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ctx_status_ctrl #(.NCTX(N), .DW(DW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start_i  (c_start),
        .cmd_park_i   (c_park),
        .cmd_free_i   (c_free),
        .cmd_kill_i   (c_kill),
        .start_dly_i  (dly),
        .state_o      (state_o),
        .exec_en_o    (exec_en_o),
        .all_halted_o (all_halted_o)
    );

    task automatic chk(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act_v, exp_v, $time);
        end
    endtask

    function automatic int st(input int i);
        return int'(state_o[2*i +: 2]);
    endfunction

    task automatic clear_cmds();
        c_start = '0; c_park = '0; c_free = '0; c_kill = '0; dly = '0;
    endtask

    task automatic do_reset();
        clear_cmds();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // kind bits: 0 start, 1 park, 2 free, 3 kill; called at a falling edge
    task automatic issue(input int c, input int kind, input int d);
        c_start[c] = kind[0];
        c_park[c]  = kind[1];
        c_free[c]  = kind[2];
        c_kill[c]  = kind[3];
        dly[DW*c +: DW] = DW'(d);
        @(negedge clk);
        clear_cmds();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_cmds();
        rst_n = 1'b0;
        @(negedge clk);
        // R2 during reset
        for (int i = 0; i < N; i++) chk("R2 state in reset", st(i), 0);
        chk("R2 exec in reset", int'(exec_en_o), 0);
        do_reset();
        for (int i = 0; i < N; i++) chk("R2 R1 state after reset", st(i), 0);
        chk("R2 all_halted after reset", int'(all_halted_o), 0);

        // R3 R4 R11: delay sweep on every context
        for (int c = 0; c < N; c++) begin
            for (int d = 0; d < 16; d++) begin
                int k;
                int expd;
                do_reset();
                expd = (d < 1) ? 1 : d;
                issue(c, 1, d);
                k = 1;
                while (st(c) != 1 && k < 20) begin
                    chk("R3 state before expiry", st(c), 0);
                    chk("R4 exec low before run", int'(exec_en_o[c]), 0);
                    @(negedge clk);
                    k++;
                end
                chk("R3 start latency", k, expd);
                chk("R4 exec high when running", int'(exec_en_o[c]), 1);
                for (int o = 0; o < N; o++)
                    if (o != c) chk("R11 other context untouched", st(o), 0);
            end
        end

        // R3: start to a running context has no effect
        do_reset();
        issue(0, 1, 1);
        issue(0, 1, 5);
        for (int k = 0; k < 7; k++) begin
            chk("R3 start on running ignored", st(0), 1);
            @(negedge clk);
        end

        // R3: restart of a countdown
        do_reset();
        issue(0, 1, 9);
        idle(2);
        issue(0, 1, 2);
        chk("R3 restart not yet running", st(0), 0);
        @(negedge clk);
        chk("R3 restart running after new delay", st(0), 1);

        // R7: park cancels countdown
        do_reset();
        issue(0, 1, 5);
        idle(2);
        issue(0, 2, 0);
        chk("R7 park during countdown", st(0), 2);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R7 no late start after park", st(0), 2);
        end

        // R7: release cancels countdown from parked
        issue(0, 1, 6);
        idle(1);
        issue(0, 4, 0);
        chk("R6 release during countdown", st(0), 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R7 no late start after release", st(0), 0);
        end

        // R5: park a running context, resume with delay 3
        do_reset();
        issue(2, 1, 1);
        issue(2, 2, 0);
        chk("R5 parked", st(2), 2);
        chk("R4 exec low when parked", int'(exec_en_o[2]), 0);
        issue(2, 1, 3);
        chk("R5 resume pending 1", st(2), 2);
        @(negedge clk);
        chk("R5 resume pending 2", st(2), 2);
        @(negedge clk);
        chk("R5 resumed", st(2), 1);

        // R10: every command mix from running and from parked
        for (int s = 0; s < 2; s++) begin
            for (int m = 1; m < 16; m++) begin
                int e;
                do_reset();
                issue(0, 1, 1);
                if (s == 1) issue(0, 2, 0);
                issue(0, m, 1);
                e = m[3] ? 3 : (m[2] ? 0 : (m[1] ? 2 : 1));
                chk("R10 priority", st(0), e);
            end
        end

        // R8: shut-down ignores all commands
        do_reset();
        issue(1, 8, 0);
        chk("R8 shut down", st(1), 3);
        for (int kind = 1; kind < 8; kind++) begin
            issue(1, kind, 3);
            idle(4);
            chk("R8 commands ignored", st(1), 3);
            chk("R4 exec low when shut down", int'(exec_en_o[1]), 0);
        end
        chk("R9 not all shut down", int'(all_halted_o), 0);

        // R9: terminate only after the last context shuts down
        do_reset();
        for (int i = 0; i < N; i++) begin
            issue(i, 8, 0);
            chk("R9 all_halted", int'(all_halted_o), (i == N - 1) ? 1 : 0);
        end
        idle(3);
        chk("R9 all_halted holds", int'(all_halted_o), 1);
        do_reset();
        chk("R8 reset leaves shut down", st(0), 0);
        chk("R9 cleared by reset", int'(all_halted_o), 0);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule